// File: doc/BRIEF.md
# Two-Tier Round-Robin Descriptor Ring Job Arbiter

This block picks the next job for a single processing element from a set of buffer-descriptor rings. The rings are split into an urgent tier and a background tier. Each ring has a 4-bit producer index, which the host advances as it posts jobs, and a 4-bit consumer index, which the arbiter keeps. A ring has work waiting whenever the two indices differ. The descriptor at the head of each ring is presented as plain register inputs: a task identifier, a repeat count and a completion-mode bit.

A job is granted only when the processing element is idle. When a job is granted, the arbiter latches its descriptor and holds it on the job outputs. The processing element answers with one done pulse per pass. A descriptor may ask for extra passes over adjacent data blocks, and those passes run without a new grant. After the last pass the arbiter does three things. It emits a one-cycle completion report carrying the ring and task identifier. It bumps that ring's consumer index. It sets a sticky bit for the ring: an interrupt-pending bit or a polled-status bit, chosen by the ring's mode bit. The host clears these bits with a write-one-to-clear vector.

Top module: `ring_job_arbiter`

## Requirements
- R1: Ring i's producer index is `prod_idx_i[4*i+3:4*i]` and its consumer index is `cons_idx_o[4*i+3:4*i]`. A ring requests service exactly when these differ, and only a requesting ring is ever granted. Indices wrap modulo 16.
- R2: Rings 0..7 form the urgent tier and rings 8..15 the background tier. A background ring is never granted while any urgent ring requests.
- R3: Each tier has its own rotating pointer. The search in a tier starts at its pointer. After a grant in that tier, the pointer moves to the ring just after the granted one, wrapping at the tier's end. The other tier's pointer does not move.
- R4: Only one job is in flight at a time. While `job_valid_o` is high, `job_ring_o`, `job_task_o` and `job_pass_o` hold steady until a done pulse arrives. A done pulse while no job is in flight changes nothing.
- R5: Ring i's repeat count is `desc_rpt_i[3*i+2:3*i]`, with value n. The granted job then takes n+1 done pulses, `job_pass_o` counts 0..n, and only the last pulse completes it.
- R6: The last done pulse of a job raises `cmpl_valid_o` for exactly one cycle, starting the cycle after the pulse. In that cycle `cmpl_ring_o` and `cmpl_task_o` equal the granted job's values, and that ring's consumer index has advanced by one (mod 16). `job_valid_o` falls in the same cycle.
- R7: The ring's mode bit `irq_mode_i[i]` is latched at grant. Value 1 sets `irq_pend_o[i]`; value 0 sets `poll_done_o[i]`. Both bits are sticky, and `irq_o` is the OR of `irq_pend_o`.
- R8: Writing a 1 to `stat_clr_i[i]` for one cycle clears both status bits of ring i on the next edge. Bits of other rings are left unchanged. A completion in the same cycle wins over a clear.
- R9: After reset there is no job in flight and no completion. All consumer indices and status bits are zero, and both tier pointers are at their tier's first ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_idx_i | input | 64 | Producer index per ring, 4 bits each |
| desc_task_i | input | 128 | Head-descriptor task identifier per ring, 8 bits each |
| desc_rpt_i | input | 48 | Head-descriptor extra-pass count per ring, 3 bits each |
| irq_mode_i | input | 16 | Completion mode per ring: 1 interrupt, 0 polled |
| pe_done_i | input | 1 | Processing element finished one pass |
| stat_clr_i | input | 16 | Write-one-to-clear for both status bits per ring |
| job_valid_o | output | 1 | A job is in flight |
| job_ring_o | output | 4 | Ring of the job in flight |
| job_task_o | output | 8 | Task identifier of the job in flight |
| job_pass_o | output | 3 | Current pass number of the job in flight |
| cmpl_valid_o | output | 1 | One-cycle completion report |
| cmpl_ring_o | output | 4 | Ring of the completed job |
| cmpl_task_o | output | 8 | Task identifier of the completed job |
| cons_idx_o | output | 64 | Consumer index per ring, 4 bits each |
| irq_pend_o | output | 16 | Sticky interrupt-pending bits |
| irq_o | output | 1 | OR of all interrupt-pending bits |
| poll_done_o | output | 16 | Sticky polled-completion bits |

## Verification
The arbiter is driven by a bench model that keeps its own consumer indices and tier pointers. Each grant is predicted from the current producer indices and compared with the design.

- A single background ring with two jobs checks request detection and the polled path on their own.
- Setting all sixteen rings pending at once shows urgent-before-background ordering and the rotation inside each tier, as it continues from wherever the earlier traffic left the pointers.
- An urgent ring posted while a background job is still running separates "no preemption" from "urgent next".
- A multi-pass descriptor checks the repeat count and the single completion.
- Seventeen back-to-back jobs on one ring walk its index across the 4-bit wrap.
- Selective clears and an idle done pulse confirm that the other state is left untouched.

// File: rtl/ring_job_arbiter.sv
module ring_job_arbiter #(
  parameter int HI_RINGS = 8,
  parameter int LO_RINGS = 8,
  parameter int IDX_W    = 4,
  parameter int TASK_W   = 8,
  parameter int RPT_W    = 3,
  localparam int NR      = HI_RINGS + LO_RINGS,
  localparam int RING_W  = $clog2(NR),
  localparam int HP_W    = $clog2(HI_RINGS > 1 ? HI_RINGS : 2),
  localparam int LP_W    = $clog2(LO_RINGS > 1 ? LO_RINGS : 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NR*IDX_W-1:0]   prod_idx_i,
  input  logic [NR*TASK_W-1:0]  desc_task_i,
  input  logic [NR*RPT_W-1:0]   desc_rpt_i,
  input  logic [NR-1:0]         irq_mode_i,
  input  logic                  pe_done_i,
  input  logic [NR-1:0]         stat_clr_i,
  output logic                  job_valid_o,
  output logic [RING_W-1:0]     job_ring_o,
  output logic [TASK_W-1:0]     job_task_o,
  output logic [RPT_W-1:0]      job_pass_o,
  output logic                  cmpl_valid_o,
  output logic [RING_W-1:0]     cmpl_ring_o,
  output logic [TASK_W-1:0]     cmpl_task_o,
  output logic [NR*IDX_W-1:0]   cons_idx_o,
  output logic [NR-1:0]         irq_pend_o,
  output logic                  irq_o,
  output logic [NR-1:0]         poll_done_o
);

  logic [IDX_W-1:0]  cons [NR];
  logic [NR-1:0]     req;
  logic [HP_W-1:0]   hi_ptr, hi_sel;
  logic [LP_W-1:0]   lo_ptr, lo_sel;
  logic              hi_hit, lo_hit;
  logic              busy, mode_q, grant, last_done;
  logic [RING_W-1:0] ring_q, gnt_ring;
  logic [TASK_W-1:0] task_q;
  logic [RPT_W-1:0]  rpt_q, pass_q;
  logic [NR-1:0]     set_vec, irq_q, poll_q;

  always_comb begin
    for (int i = 0; i < NR; i++) req[i] = prod_idx_i[i*IDX_W +: IDX_W] != cons[i];
  end

  for (genvar g = 0; g < NR; g++) begin : g_cons_out
    assign cons_idx_o[g*IDX_W +: IDX_W] = cons[g];
  end

  always_comb begin
    hi_hit = 1'b0;
    hi_sel = '0;
    for (int k = HI_RINGS - 1; k >= 0; k--) begin
      if (req[(int'(hi_ptr) + k) % HI_RINGS]) begin
        hi_hit = 1'b1;
        hi_sel = HP_W'((int'(hi_ptr) + k) % HI_RINGS);
      end
    end
  end

  always_comb begin
    lo_hit = 1'b0;
    lo_sel = '0;
    for (int k = LO_RINGS - 1; k >= 0; k--) begin
      if (req[HI_RINGS + (int'(lo_ptr) + k) % LO_RINGS]) begin
        lo_hit = 1'b1;
        lo_sel = LP_W'((int'(lo_ptr) + k) % LO_RINGS);
      end
    end
  end

  assign grant     = !busy && (hi_hit || lo_hit);
  assign gnt_ring  = hi_hit ? RING_W'(hi_sel) : RING_W'(HI_RINGS + int'(lo_sel));
  assign last_done = busy && pe_done_i && (pass_q == rpt_q);

  always_comb begin
    set_vec = '0;
    if (last_done) set_vec[ring_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      ring_q       <= '0;
      task_q       <= '0;
      rpt_q        <= '0;
      pass_q       <= '0;
      mode_q       <= 1'b0;
      hi_ptr       <= '0;
      lo_ptr       <= '0;
      cmpl_valid_o <= 1'b0;
      irq_q        <= '0;
      poll_q       <= '0;
      for (int i = 0; i < NR; i++) cons[i] <= '0;
    end else begin
      cmpl_valid_o <= last_done;
      irq_q        <= (irq_q  & ~stat_clr_i) | (mode_q ? set_vec : '0);
      poll_q       <= (poll_q & ~stat_clr_i) | (mode_q ? '0 : set_vec);
      if (grant) begin
        busy   <= 1'b1;
        ring_q <= gnt_ring;
        task_q <= desc_task_i[gnt_ring*TASK_W +: TASK_W];
        rpt_q  <= desc_rpt_i[gnt_ring*RPT_W +: RPT_W];
        mode_q <= irq_mode_i[gnt_ring];
        pass_q <= '0;
        if (hi_hit) hi_ptr <= (int'(hi_sel) == HI_RINGS - 1) ? '0 : hi_sel + 1'b1;
        else        lo_ptr <= (int'(lo_sel) == LO_RINGS - 1) ? '0 : lo_sel + 1'b1;
      end else if (last_done) begin
        busy         <= 1'b0;
        cons[ring_q] <= cons[ring_q] + 1'b1;
      end else if (busy && pe_done_i) begin
        pass_q <= pass_q + 1'b1;
      end
    end
  end

  assign job_valid_o = busy;
  assign job_ring_o  = ring_q;
  assign job_task_o  = task_q;
  assign job_pass_o  = pass_q;
  assign cmpl_ring_o = ring_q;
  assign cmpl_task_o = task_q;
  assign irq_pend_o  = irq_q;
  assign poll_done_o = poll_q;
  assign irq_o       = |irq_q;

endmodule

// File: rtl/ring_job_arbiter_chk.sv
module ring_job_arbiter_chk #(
  parameter int HI_RINGS = 8,
  parameter int LO_RINGS = 8,
  parameter int IDX_W    = 4,
  parameter int TASK_W   = 8,
  parameter int RPT_W    = 3,
  localparam int NR      = HI_RINGS + LO_RINGS,
  localparam int RING_W  = $clog2(NR)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NR*IDX_W-1:0]  prod_idx_i,
  input logic [NR*TASK_W-1:0] desc_task_i,
  input logic [NR*RPT_W-1:0]  desc_rpt_i,
  input logic [NR-1:0]        irq_mode_i,
  input logic                 pe_done_i,
  input logic [NR-1:0]        stat_clr_i,
  input logic                 job_valid_o,
  input logic [RING_W-1:0]    job_ring_o,
  input logic [TASK_W-1:0]    job_task_o,
  input logic [RPT_W-1:0]     job_pass_o,
  input logic                 cmpl_valid_o,
  input logic [RING_W-1:0]    cmpl_ring_o,
  input logic [TASK_W-1:0]    cmpl_task_o,
  input logic [NR*IDX_W-1:0]  cons_idx_o,
  input logic [NR-1:0]        irq_pend_o,
  input logic                 irq_o,
  input logic [NR-1:0]        poll_done_o
);

  logic [NR-1:0] pend;
  always_comb begin
    for (int i = 0; i < NR; i++)
      pend[i] = prod_idx_i[i*IDX_W +: IDX_W] != cons_idx_o[i*IDX_W +: IDX_W];
  end

  a_r1_granted_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(job_valid_o) |-> (($past(pend) & (NR'(1) << job_ring_o)) != '0));

  a_r2_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(job_valid_o) && (int'(job_ring_o) >= HI_RINGS)) |-> ($past(pend[HI_RINGS-1:0]) == '0));

  a_r4_job_held: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid_o && !pe_done_i) |=>
      (job_valid_o && $stable(job_ring_o) && $stable(job_task_o) && $stable(job_pass_o)));

  a_r7_one_new_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0((irq_pend_o & ~$past(irq_pend_o)) | (poll_done_o & ~$past(poll_done_o))));

  for (genvar g = 0; g < NR; g++) begin : g_ring
    a_r6_cons_steps_on_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cons_idx_o[g*IDX_W +: IDX_W]) |->
        (cmpl_valid_o && cmpl_ring_o == RING_W'(g) &&
         cons_idx_o[g*IDX_W +: IDX_W] == $past(cons_idx_o[g*IDX_W +: IDX_W]) + 1'b1));
  end

endmodule

bind ring_job_arbiter ring_job_arbiter_chk #(
  .HI_RINGS(HI_RINGS), .LO_RINGS(LO_RINGS), .IDX_W(IDX_W), .TASK_W(TASK_W), .RPT_W(RPT_W)
) u_chk (.*);

// File: tb/ring_job_arbiter_bench.sv
module ring_job_arbiter_bench;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NR*4-1:0] prod_bus;
  logic [NR*8-1:0] task_bus;
  logic [NR*3-1:0] rpt_bus;
  logic [NR-1:0]   mode_bus = '0;
  logic            done = 1'b0;
  logic [NR-1:0]   clr = '0;
  logic            job_valid, cmpl_valid, irq;
  logic [3:0]      job_ring, cmpl_ring;
  logic [7:0]      job_task, cmpl_task;
  logic [2:0]      job_pass;
  logic [NR*4-1:0] cons_bus;
  logic [NR-1:0]   irq_pend, poll_done;

  int prod [NR];
  int rpt  [NR];
  int exp_cons [NR];
  int m_hi = 0, m_lo = 0;
  logic [NR-1:0] exp_irq = '0, exp_poll = '0;
  int checks = 0, fails = 0, cur = -1;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      prod_bus[i*4 +: 4] = 4'(prod[i]);
      rpt_bus[i*3 +: 3]  = 3'(rpt[i]);
      task_bus[i*8 +: 8] = 8'(8'hA0 ^ (i * 7));
    end
  end

  ring_job_arbiter u_ring_job_arbiter (
    .clk(clk), .rst_n(rst_n), .prod_idx_i(prod_bus), .desc_task_i(task_bus),
    .desc_rpt_i(rpt_bus), .irq_mode_i(mode_bus), .pe_done_i(done), .stat_clr_i(clr),
    .job_valid_o(job_valid), .job_ring_o(job_ring), .job_task_o(job_task),
    .job_pass_o(job_pass), .cmpl_valid_o(cmpl_valid), .cmpl_ring_o(cmpl_ring),
    .cmpl_task_o(cmpl_task), .cons_idx_o(cons_bus), .irq_pend_o(irq_pend),
    .irq_o(irq), .poll_done_o(poll_done));

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int predict();
    for (int off = 0; off < 8; off++)
      if ((prod[(m_hi + off) % 8] & 15) != exp_cons[(m_hi + off) % 8]) return (m_hi + off) % 8;
    for (int off = 0; off < 8; off++)
      if ((prod[8 + (m_lo + off) % 8] & 15) != exp_cons[8 + (m_lo + off) % 8]) return 8 + (m_lo + off) % 8;
    return -1;
  endfunction

  task automatic wait_grant();
    int r;
    for (int t = 0; t < 40 && !job_valid; t++) @(negedge clk);
    r = predict();
    check(job_valid == 1'b1, "R4 job granted", job_valid, 1);
    check(int'(job_ring) == r, "R2/R3 granted ring", job_ring, r);
    check(job_task == 8'(8'hA0 ^ (r * 7)), "R4 job task", job_task, 8'(8'hA0 ^ (r * 7)));
    if (r < 8) m_hi = (r + 1) % 8; else m_lo = (r - 8 + 1) % 8;
    cur = r;
  endtask

  task automatic finish_job();
    for (int p = 0; p <= rpt[cur]; p++) begin
      check(int'(job_pass) == p, "R5 pass number", job_pass, p);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
    end
    exp_cons[cur] = (exp_cons[cur] + 1) & 15;
    if (mode_bus[cur]) exp_irq[cur] = 1'b1; else exp_poll[cur] = 1'b1;
    check(cmpl_valid == 1'b1, "R6 completion pulse", cmpl_valid, 1);
    check(int'(cmpl_ring) == cur, "R6 completion ring", cmpl_ring, cur);
    check(cmpl_task == 8'(8'hA0 ^ (cur * 7)), "R6 completion task", cmpl_task, 8'(8'hA0 ^ (cur * 7)));
    check(job_valid == 1'b0, "R6 job released", job_valid, 0);
    check(int'(cons_bus[cur*4 +: 4]) == exp_cons[cur], "R1 consumer index", cons_bus[cur*4 +: 4], exp_cons[cur]);
    check(irq_pend == exp_irq, "R7 interrupt bits", irq_pend, exp_irq);
    check(poll_done == exp_poll, "R7 polled bits", poll_done, exp_poll);
    check(irq == (exp_irq != '0), "R7 irq line", irq, exp_irq != '0);
  endtask

  task automatic run_job();
    wait_grant();
    finish_job();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin prod[i] = 0; rpt[i] = 0; exp_cons[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(job_valid == 1'b0, "R9 no job", job_valid, 0);
    check(cmpl_valid == 1'b0, "R9 no completion", cmpl_valid, 0);
    check(cons_bus == '0, "R9 consumer indices", cons_bus, 0);
    check(irq_pend == '0 && poll_done == '0 && !irq, "R9 status clear", irq_pend, 0);

    // R4 done while idle is ignored
    done = 1'b1; @(negedge clk); done = 1'b0; @(negedge clk);
    check(cons_bus == '0 && !cmpl_valid && !job_valid, "R4 idle done ignored", cons_bus, 0);

    // R1 R7 single background ring, polled
    prod[11] = 2;
    run_job(); run_job();
    repeat (3) @(negedge clk);
    check(job_valid == 1'b0, "R1 no request when indices equal", job_valid, 0);

    // R2 R3 all rings pending, urgent tier in interrupt mode
    mode_bus = 16'h00FF;
    for (int i = 0; i < NR; i++) prod[i] = (prod[i] + 1) & 15;
    for (int j = 0; j < NR; j++) run_job();

    // R4 urgent request arriving during a background job does not preempt
    prod[12] = (prod[12] + 1) & 15;
    wait_grant();
    prod[1] = (prod[1] + 1) & 15;
    repeat (4) @(negedge clk);
    check(job_valid && job_ring == 4'd12, "R4 no preemption", job_ring, 12);
    finish_job();
    run_job();
    check(cur == 1, "R2 urgent served next", cur, 1);

    // R5 multi-pass descriptor
    rpt[5] = 3;
    prod[5] = (prod[5] + 1) & 15;
    run_job();
    rpt[5] = 0;

    // R1 index wrap on one ring
    for (int j = 0; j < 17; j++) begin
      prod[9] = (prod[9] + 1) & 15;
      run_job();
    end

    // R8 selective write-one-to-clear
    clr = 16'h0801;
    @(negedge clk);
    clr = '0;
    exp_irq[0] = 1'b0; exp_poll[11] = 1'b0;
    @(negedge clk);
    check(irq_pend == exp_irq, "R8 interrupt bits after clear", irq_pend, exp_irq);
    check(poll_done == exp_poll, "R8 polled bits after clear", poll_done, exp_poll);
    clr = '1;
    @(negedge clk);
    clr = '0;
    @(negedge clk);
    check(irq_pend == '0 && poll_done == '0 && !irq, "R8 clear all", irq_pend, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule